// File: doc/BRIEF.md
# SPI Byte-Transfer Core

This block is the data path of an SPI master. It holds a transmit queue and a receive queue of 8-bit words, each 128 entries deep. A shift engine moves one word at a time out on the serial output, most significant bit first. It advances one bit per strobe from an external bit-clock generator. On every strobe it samples the serial input, so each word sent yields exactly one received word, which lands in the receive queue. The serial clock itself is produced elsewhere. The engine only reports when it is shifting and consumes the strobes it is given.

Software, or a sequencer acting for it, pushes words into the transmit queue and pops words from the receive queue. A programmable watermark raises a refill request whenever transmit occupancy drops below it. Word transfers start on their own when data is present, or only after an explicit start pulse when that mode is chosen. The 4-bit active-low select field encodes the target device in one of two ways: one line per device, or a raw binary index for an outside decoder. The field is driven either by hand or only while a word is shifting. A mode-fault input, which reports another master taking the bus, aborts shifting and blocks further starts until the block is disabled.

Top module: `spi_xfer_core`

## Requirements
- R1: After reset `cs_n` is 4'b1111, `tx_full`, `rx_not_empty`, `mode_fault` and `shift_busy` are 0, `rx_data` is 0, and `tx_below_wm` is 1 whenever `watermark` is above zero.
- R2: Each queue holds 128 words. `tx_full` is 1 exactly when 128 words are waiting. A push while full is dropped and that word is never shifted.
- R3: `tx_below_wm` is 1 exactly when transmit occupancy is strictly less than `watermark`.
- R4: A started word appears on `mosi` MSB first, one bit per `shift_tick`. On each tick `miso` is shifted in. After the 8th tick the received word enters the receive queue, so with `miso` tied to `mosi` the word comes back unchanged.
- R5: `rx_data` shows the oldest received word, or 0 when the receive queue is empty. A pop on an empty queue changes nothing.
- R6: With `manual_start_en` low, a word starts on its own when `enable` is high, the transmit queue holds data and the receive queue has room.
- R7: With `manual_start_en` high, nothing starts until a `start_pulse`. The pulse arms the engine, which stays armed until it is idle with an empty transmit queue.
- R8: With `enable` low no word starts, ticks are ignored and queued transmit words are kept. The receive queue can still be popped until `rx_not_empty` falls.
- R9: With `decode_mode` low and the select active, `cs_sel` values 0 to 3 drive bit n of `cs_n` low and the other bits high. Values 4 and above give 4'b1111.
- R10: With `decode_mode` high and the select active, `cs_n` equals `cs_sel`, and 4'b1111 means no device.
- R11: With `manual_cs` high the select is active while `cs_assert` is high. With `manual_cs` low it is active only while `shift_busy` is high. When inactive, `cs_n` is 4'b1111.
- R12: `fault_in` while enabled sets `mode_fault` on the next edge and aborts any word in flight; that word never reaches the receive queue. No word starts while `mode_fault` is set, and `enable` low clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows words to start and ticks to shift |
| manual_start_en | input | 1 | Selects start-on-pulse operation |
| start_pulse | input | 1 | One-cycle request that arms the engine |
| shift_tick | input | 1 | One-bit advance strobe from the bit-clock generator |
| tx_push | input | 1 | Writes `tx_data` into the transmit queue |
| tx_data | input | 8 | Word to transmit |
| tx_full | output | 1 | Transmit queue holds 128 words |
| tx_below_wm | output | 1 | Transmit occupancy below `watermark` |
| watermark | input | 8 | Refill threshold |
| rx_pop | input | 1 | Removes the oldest received word |
| rx_data | output | 8 | Oldest received word, 0 when empty |
| rx_not_empty | output | 1 | Receive queue holds data |
| mosi | output | 1 | Serial output bit, 0 when idle |
| miso | input | 1 | Serial input bit |
| shift_busy | output | 1 | A word is being shifted |
| fault_in | input | 1 | Another master has taken the bus |
| mode_fault | output | 1 | Sticky fault flag |
| manual_cs | input | 1 | Select follows `cs_assert` instead of `shift_busy` |
| cs_assert | input | 1 | Manual select request |
| decode_mode | input | 1 | Binary select encoding |
| cs_sel | input | 4 | Target device index |
| cs_n | output | 4 | Active-low select field |

## Verification
The checker verifies several rules on every cycle. The select field idles at all ones under automatic control and has exactly one low bit in one-line-per-device mode. A start under manual-start mode always follows an arming pulse. Nothing starts or completes while disabled. A set fault flag means the engine is idle, and an empty receive queue reads as zero. Data integrity needs the bench's scenarios. These cover loopback order and bit order under normal and inverted serial input, the dropped push at 128 entries, the watermark crossing, draining while disabled, and the word lost to a mid-transfer fault.

// File: rtl/spi_core_pkg.sv
package spi_core_pkg;
  localparam int SEL_W = 4;

  // Active-low select field for a device index.
  function automatic logic [SEL_W-1:0] sel_encode(input logic [SEL_W-1:0] idx,
                                                  input logic decoded,
                                                  input logic active);
    logic [SEL_W-1:0] f;
    f = '1;
    if (active) begin
      if (decoded) f = idx;
      else if (idx < SEL_W'(SEL_W)) f = ~(SEL_W'(1) << idx);
    end
    return f;
  endfunction

  // Refill request: occupancy strictly under the threshold.
  function automatic logic below_mark(input logic [15:0] level, input logic [15:0] mark);
    return level < mark;
  endfunction
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] level
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, empty, do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level == CW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/shift_engine.sv
module shift_engine #(
  parameter int DW = 8,
  localparam int NW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          fault_in,
  input  logic          manual_start_en,
  input  logic          start_pulse,
  input  logic          tick,
  input  logic          miso,
  input  logic          tx_avail,
  input  logic          rx_room,
  input  logic [DW-1:0] tx_word,
  output logic          busy,
  output logic          mosi,
  output logic          load,
  output logic          done,
  output logic [DW-1:0] rx_word,
  output logic          fault,
  output logic          armed
);
  logic [DW-1:0] shreg;
  logic [NW-1:0] bit_cnt;
  logic          step, last;

  assign load    = enable && !fault && !fault_in && !busy && tx_avail && rx_room &&
                   (!manual_start_en || armed);
  assign step    = enable && busy && tick && !fault_in;
  assign last    = (bit_cnt == NW'(DW - 1));
  assign done    = step && last;
  assign rx_word = {shreg[DW-2:0], miso};
  assign mosi    = busy ? shreg[DW-1] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      shreg   <= '0;
      bit_cnt <= '0;
      fault   <= 1'b0;
      armed   <= 1'b0;
    end else begin
      if (!enable)       fault <= 1'b0;
      else if (fault_in) fault <= 1'b1;

      if (start_pulse)            armed <= 1'b1;
      else if (!busy && !tx_avail) armed <= 1'b0;

      if (enable && fault_in) begin
        busy    <= 1'b0;
        bit_cnt <= '0;
      end else if (load) begin
        busy    <= 1'b1;
        shreg   <= tx_word;
        bit_cnt <= '0;
      end else if (step) begin
        shreg   <= rx_word;
        bit_cnt <= last ? '0 : bit_cnt + 1'b1;
        if (last) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sel_encoder.sv
module sel_encoder
  import spi_core_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             decoded,
  input  logic             active,
  output logic [SEL_W-1:0] field_n
);
  assign field_n = sel_encode(sel, decoded, active);
endmodule

// File: rtl/spi_xfer_core.sv
module spi_xfer_core
  import spi_core_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 128,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             manual_start_en,
  input  logic             start_pulse,
  input  logic             shift_tick,
  input  logic             tx_push,
  input  logic [DW-1:0]    tx_data,
  output logic             tx_full,
  output logic             tx_below_wm,
  input  logic [CW-1:0]    watermark,
  input  logic             rx_pop,
  output logic [DW-1:0]    rx_data,
  output logic             rx_not_empty,
  output logic             mosi,
  input  logic             miso,
  output logic             shift_busy,
  input  logic             fault_in,
  output logic             mode_fault,
  input  logic             manual_cs,
  input  logic             cs_assert,
  input  logic             decode_mode,
  input  logic [SEL_W-1:0] cs_sel,
  output logic [SEL_W-1:0] cs_n
);
  // Internal events brought out by name for the checker.
  logic          load_evt, done_evt, armed_st;
  logic [CW-1:0] tx_level, rx_level;
  logic [DW-1:0] tx_head, rx_word;

  byte_fifo #(.DW(DW), .DEPTH(DEPTH)) tx_q (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_data),
    .pop(load_evt), .rdata(tx_head), .level(tx_level));

  byte_fifo #(.DW(DW), .DEPTH(DEPTH)) rx_q (
    .clk(clk), .rst_n(rst_n), .push(done_evt), .wdata(rx_word),
    .pop(rx_pop), .rdata(rx_data), .level(rx_level));

  shift_engine #(.DW(DW)) eng (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fault_in(fault_in),
    .manual_start_en(manual_start_en), .start_pulse(start_pulse),
    .tick(shift_tick), .miso(miso),
    .tx_avail(tx_level != '0), .rx_room(rx_level != CW'(DEPTH)),
    .tx_word(tx_head), .busy(shift_busy), .mosi(mosi), .load(load_evt),
    .done(done_evt), .rx_word(rx_word), .fault(mode_fault), .armed(armed_st));

  sel_encoder enc (
    .sel(cs_sel), .decoded(decode_mode),
    .active(manual_cs ? cs_assert : shift_busy), .field_n(cs_n));

  assign tx_full      = (tx_level == CW'(DEPTH));
  assign tx_below_wm  = below_mark(16'(tx_level), 16'(watermark));
  assign rx_not_empty = (rx_level != '0);
endmodule

// File: rtl/spi_xfer_core_chk.sv
module spi_xfer_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       manual_cs,
  input logic       manual_start_en,
  input logic       decode_mode,
  input logic       shift_busy,
  input logic [3:0] cs_n,
  input logic       load_evt,
  input logic       done_evt,
  input logic       armed_st,
  input logic       rx_not_empty,
  input logic [7:0] rx_data,
  input logic       mode_fault,
  input logic       tx_full
);
  // R11
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual_cs && !shift_busy) |-> (cs_n == 4'hF));
  // R9
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!decode_mode && cs_n != 4'hF) |-> ($countones(cs_n) == 3));
  // R7
  manual_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && manual_start_en) |-> armed_st);
  // R8
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!load_evt && !done_evt));
  // R5
  rx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_not_empty |-> (rx_data == 8'h00));
  // R12
  fault_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fault |-> !shift_busy);
  // R12
  fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !mode_fault);
  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && !load_evt) |=> tx_full);
  // R4
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> shift_busy);
endmodule

bind spi_xfer_core spi_xfer_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .manual_cs(manual_cs),
  .manual_start_en(manual_start_en), .decode_mode(decode_mode),
  .shift_busy(shift_busy), .cs_n(cs_n), .load_evt(load_evt),
  .done_evt(done_evt), .armed_st(armed_st), .rx_not_empty(rx_not_empty),
  .rx_data(rx_data), .mode_fault(mode_fault), .tx_full(tx_full));

// File: tb/spi_xfer_core_test.sv
`timescale 1ns/1ps
module spi_xfer_core_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, manual_start_en = 1'b0, start_pulse = 1'b0, shift_tick = 1'b0;
  logic tx_push = 1'b0, rx_pop = 1'b0, fault_in = 1'b0;
  logic manual_cs = 1'b0, cs_assert = 1'b0, decode_mode = 1'b0;
  logic [7:0] tx_data = 8'h00, watermark = 8'd1;
  logic [3:0] cs_sel = 4'h0;
  logic tx_full, tx_below_wm, rx_not_empty, mosi, miso, shift_busy, mode_fault;
  logic [7:0] rx_data;
  logic [3:0] cs_n;
  logic tick_en = 1'b0, inv = 1'b0, finished = 1'b0;
  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;
  assign miso = mosi ^ inv;

  spi_xfer_core uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .manual_start_en(manual_start_en),
    .start_pulse(start_pulse), .shift_tick(shift_tick), .tx_push(tx_push),
    .tx_data(tx_data), .tx_full(tx_full), .tx_below_wm(tx_below_wm),
    .watermark(watermark), .rx_pop(rx_pop), .rx_data(rx_data),
    .rx_not_empty(rx_not_empty), .mosi(mosi), .miso(miso), .shift_busy(shift_busy),
    .fault_in(fault_in), .mode_fault(mode_fault), .manual_cs(manual_cs),
    .cs_assert(cs_assert), .decode_mode(decode_mode), .cs_sel(cs_sel), .cs_n(cs_n));

  // Bit strobe: every other cycle while enabled.
  initial forever begin
    @(negedge clk);
    shift_tick = tick_en ? !shift_tick : 1'b0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Driver: push one word and record the word expected back.
  task automatic push_word(input logic [7:0] d, input bit expect_back);
    @(negedge clk);
    tx_push = 1'b1; tx_data = d;
    if (expect_back) exp_q.push_back(d ^ {8{inv}});
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (tx_below_wm && !shift_busy && i > 1) break;
    end
  endtask

  // Monitor: pop every received word and compare with the scoreboard.
  task automatic drain(input string req);
    @(negedge clk);
    while (rx_not_empty) begin
      if (exp_q.size() == 0) chk({req, " extra word"}, {24'h0, rx_data}, 32'hDEAD);
      else chk(req, {24'h0, rx_data}, {24'h0, exp_q.pop_front()});
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
      @(negedge clk);
    end
    chk({req, " all words returned"}, exp_q.size(), 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 cs_n", cs_n, 4'hF);
    chk("R1 tx_full", tx_full, 0);
    chk("R1 tx_below_wm", tx_below_wm, 1);
    chk("R1 rx_not_empty", rx_not_empty, 0);
    chk("R1 mode_fault", mode_fault, 0);
    chk("R1 shift_busy", shift_busy, 0);
    chk("R1 rx_data", rx_data, 0);

    // R4 R6 loopback, automatic start
    enable = 1'b1; tick_en = 1'b1;
    push_word(8'hA5, 1); push_word(8'h3C, 1); push_word(8'h01, 1);
    wait_idle();
    drain("R4 R6 loopback");

    // R4 inverted serial input
    inv = 1'b1;
    push_word(8'h0F, 1); push_word(8'h80, 1);
    wait_idle();
    drain("R4 inverted");
    inv = 1'b0;

    // R5 pop on empty
    @(negedge clk); rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0; @(negedge clk);
    chk("R5 empty pop flag", rx_not_empty, 0);
    chk("R5 empty read zero", rx_data, 0);

    // R2 R3 R8 fill while disabled
    enable = 1'b0; watermark = 8'd64;
    for (int i = 0; i < 63; i++) push_word(8'(i * 7 + 3), 1);
    chk("R3 below at 63", tx_below_wm, 1);
    push_word(8'h40, 1);
    chk("R3 not below at 64", tx_below_wm, 0);
    for (int i = 0; i < 63; i++) push_word(8'(i * 11 + 5), 1);
    chk("R2 not full at 127", tx_full, 0);
    push_word(8'h7F, 1);
    chk("R2 full at 128", tx_full, 1);
    push_word(8'hEE, 0);
    chk("R2 full after dropped push", tx_full, 1);
    idle(40);
    chk("R8 no shifting while disabled", shift_busy, 0);
    chk("R8 nothing received while disabled", rx_not_empty, 0);
    watermark = 8'd1; enable = 1'b1;
    wait_idle();
    drain("R2 128 words, dropped push absent");

    // R8 drain while disabled
    push_word(8'h5A, 1); push_word(8'hC3, 1);
    wait_idle();
    enable = 1'b0;
    drain("R8 drain while disabled");
    enable = 1'b1;

    // R7 manual start
    manual_start_en = 1'b1;
    push_word(8'h55, 1);
    idle(40);
    chk("R7 no start without pulse", shift_busy, 0);
    chk("R7 word still queued", tx_below_wm, 0);
    chk("R7 nothing received", rx_not_empty, 0);
    @(negedge clk); start_pulse = 1'b1; @(negedge clk); start_pulse = 1'b0;
    wait_idle();
    drain("R7 after pulse");
    manual_start_en = 1'b0;

    // R9 R10 R11 select encoding, manual control
    manual_cs = 1'b1; cs_assert = 1'b1; decode_mode = 1'b0;
    cs_sel = 4'd0; idle(1); chk("R9 sel 0", cs_n, 4'hE);
    cs_sel = 4'd2; idle(1); chk("R9 sel 2", cs_n, 4'hB);
    cs_sel = 4'd3; idle(1); chk("R9 sel 3", cs_n, 4'h7);
    cs_sel = 4'd6; idle(1); chk("R9 sel 6 none", cs_n, 4'hF);
    decode_mode = 1'b1;
    cs_sel = 4'd5; idle(1); chk("R10 sel 5", cs_n, 4'h5);
    cs_sel = 4'd0; idle(1); chk("R10 sel 0", cs_n, 4'h0);
    cs_assert = 1'b0; idle(1); chk("R11 manual release", cs_n, 4'hF);
    // R11 automatic control
    manual_cs = 1'b0; decode_mode = 1'b0; cs_sel = 4'd1;
    idle(1); chk("R11 auto idle", cs_n, 4'hF);
    push_word(8'h99, 1);
    for (int i = 0; i < 20 && !shift_busy; i++) idle(1);
    chk("R11 auto while shifting", cs_n, 4'hD);
    wait_idle();
    chk("R11 auto after word", cs_n, 4'hF);
    drain("R11 word");

    // R12 fault blocks starts
    @(negedge clk); fault_in = 1'b1; @(negedge clk); fault_in = 1'b0;
    chk("R12 fault set", mode_fault, 1);
    push_word(8'h77, 1);
    idle(40);
    chk("R12 no start under fault", shift_busy, 0);
    chk("R12 nothing received under fault", rx_not_empty, 0);
    enable = 1'b0; idle(1);
    chk("R12 cleared by disable", mode_fault, 0);
    enable = 1'b1;
    wait_idle();
    drain("R12 after clear");
    // R12 abort in flight
    tick_en = 1'b0;
    push_word(8'h3E, 0);
    idle(2);
    chk("R12 word in flight", shift_busy, 1);
    @(negedge clk); fault_in = 1'b1; @(negedge clk); fault_in = 1'b0;
    chk("R12 aborted", shift_busy, 0);
    tick_en = 1'b1;
    idle(40);
    chk("R12 aborted word not received", rx_not_empty, 0);
    enable = 1'b0; idle(1); enable = 1'b1; idle(1);
    chk("R12 queue empty after abort", tx_below_wm, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule